// File: doc/BRIEF.md
# Bit-Serial Multiply-Accumulate Processing Element

This block is one processing element for a wide array that works on data one bit per clock. A weight word is loaded in parallel from the element's local weight store when a new operation starts. A multiplier bit stream is broadcast to every element, least significant bit first. A serial operand stream, the running sum, arrives on a second bit input. Each step multiplies the weight by the broadcast bit stream in a carry-save row, adds the product bit to the operand bit in a serial adder, and emits one result bit. Both units work in the same step, so a multiply-and-add costs no more steps per bit than a plain add.

A build parameter selects a counting variant in place of the multiply-accumulate datapath. In that variant each step moves a saturating signed counter up or down according to the broadcast bit. This suits memory-style workloads that accumulate votes.

Top module: `bsmac_pe`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `res_bit` is 0 and `count` is 0.
- R2: In multiply-accumulate mode, each cycle with `step` high and `start` low consumes one bit from `bcast_bit` and one from `opnd_bit`. The matching result bit appears on `res_bit` one clock edge later.
- R3: After `start` loads weight A, the caller issues 2*W+1 steps. On step k, `bcast_bit` carries bit k of the W-bit multiplier X for k < W and 0 after that. `opnd_bit` carries bit k of the 2*W-bit addend Y for k < 2*W and 0 after that. The result bits, LSB first, then form the 2*W+1-bit value A*X+Y.
- R4: With a weight of 0, the same step sequence returns the addend Y unchanged, with the same one-edge latency as a multiply.
- R5: `start` clears the adder carry, the multiplier's partial state and `res_bit`. An operation cut off part way leaves no residue in the next one.
- R6: A cycle with neither `step` nor `start` leaves `res_bit` and `count` unchanged, even if the data inputs toggle.
- R7: In counting mode, a step with `bcast_bit` = 1 raises `count` by one, and a step with `bcast_bit` = 0 lowers it by one. `count` is two's complement and CNT_W bits wide.
- R8: In counting mode, `count` saturates. It holds at 2^(CNT_W-1)-1 on further increments and at -2^(CNT_W-1) on further decrements.
- R9: In counting mode, `start` clears `count` to 0 and takes priority over a `step` in the same cycle.
- R10: The output that the selected mode does not use stays at 0: `count` in multiply-accumulate mode and `res_bit` in counting mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Loads the weight and clears all accumulation state |
| weight | input | W | Parallel multiplicand from local weight storage |
| step | input | 1 | Advances the element by one bit |
| bcast_bit | input | 1 | Broadcast serial bit: multiplier LSB first, or count direction |
| opnd_bit | input | 1 | Serial addend bit, LSB first |
| res_bit | output | 1 | Registered serial result bit |
| count | output | CNT_W | Saturating counter value (counting mode) |

## Verification
The bench builds two copies of the block. The first is multiply-accumulate mode with the default W = 8, so a full 17-step operation covers the all-ones weight, multiplier and addend case, where the final carry-out bit is set. The second is counting mode with CNT_W = 4, which brings both saturation limits (+7 and -8) within a dozen steps. Repeated hits on those limits can then be mixed with random up/down and clear traffic. Idle gaps inside a running multiply show that the partial state is held between steps.

// File: rtl/pe_pkg.sv
package pe_pkg;

  typedef enum logic {
    PE_MAC   = 1'b0,
    PE_COUNT = 1'b1
  } pe_kind_e;

  // one full-adder cell: returns {carry, sum}
  function automatic logic [1:0] fa(input logic a, input logic b, input logic c);
    fa = {(a & b) | (a & c) | (b & c), a ^ b ^ c};
  endfunction

endpackage

// File: rtl/pe_csa_mult.sv
module pe_csa_mult #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] weight,
  input  logic         step,
  input  logic         x_bit,
  output logic         prod_bit
);
  import pe_pkg::*;

  logic [W-1:0] mcand_q, mcand_d;
  logic [W-1:0] sum_q, sum_d;
  logic [W-1:0] cry_q, cry_d;
  logic [W-1:0] cell_s, cell_c;

  // one carry-save cell per weight bit; carries stay in place, sums move down
  for (genvar i = 0; i < W; i++) begin : g_cell
    always_comb begin
      {cell_c[i], cell_s[i]} = fa(mcand_q[i] & x_bit, sum_q[i], cry_q[i]);
    end
  end

  assign prod_bit = cell_s[0];

  always_comb begin
    mcand_d = mcand_q;
    sum_d   = sum_q;
    cry_d   = cry_q;
    if (load) begin
      mcand_d = weight;
      sum_d   = '0;
      cry_d   = '0;
    end else if (step) begin
      sum_d = {1'b0, cell_s[W-1:1]};
      cry_d = cell_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      sum_q   <= '0;
      cry_q   <= '0;
    end else begin
      mcand_q <= mcand_d;
      sum_q   <= sum_d;
      cry_q   <= cry_d;
    end
  end

endmodule

// File: rtl/pe_serial_adder.sv
module pe_serial_adder (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  input  logic a_bit,
  input  logic b_bit,
  output logic sum_bit
);
  import pe_pkg::*;

  logic carry_q, carry_d;
  logic sum_q, sum_d;

  always_comb begin
    carry_d = carry_q;
    sum_d   = sum_q;
    if (clear) begin
      carry_d = 1'b0;
      sum_d   = 1'b0;
    end else if (step) begin
      {carry_d, sum_d} = fa(a_bit, b_bit, carry_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      sum_q   <= 1'b0;
    end else begin
      carry_q <= carry_d;
      sum_q   <= sum_d;
    end
  end

  assign sum_bit = sum_q;

endmodule

// File: rtl/pe_sat_counter.sv
module pe_sat_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             up,
  output logic [CNT_W-1:0] value
);
  localparam logic [CNT_W-1:0] TOP = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] BOT = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (step) begin
      if (up && cnt_q != TOP) begin
        cnt_d = cnt_q + 1'b1;
      end else if (!up && cnt_q != BOT) begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign value = cnt_q;

endmodule

// File: rtl/bsmac_pe.sv
module bsmac_pe #(
  parameter int               W     = 8,
  parameter int               CNT_W = 8,
  parameter pe_pkg::pe_kind_e MODE  = pe_pkg::PE_MAC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [W-1:0]     weight,
  input  logic             step,
  input  logic             bcast_bit,
  input  logic             opnd_bit,
  output logic             res_bit,
  output logic [CNT_W-1:0] count
);
  import pe_pkg::*;

  logic step_eff;
  assign step_eff = step & ~start;

  if (MODE == PE_MAC) begin : g_mac
    logic prod_bit;

    pe_csa_mult #(.W(W)) u_mult (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .weight   (weight),
      .step     (step_eff),
      .x_bit    (bcast_bit),
      .prod_bit (prod_bit)
    );

    pe_serial_adder u_add (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start),
      .step    (step_eff),
      .a_bit   (prod_bit),
      .b_bit   (opnd_bit),
      .sum_bit (res_bit)
    );

    assign count = '0;
  end else begin : g_cnt
    logic unused_inputs;
    assign unused_inputs = ^{weight, opnd_bit};

    pe_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start),
      .step  (step_eff),
      .up    (bcast_bit),
      .value (count)
    );

    assign res_bit = 1'b0;
  end

endmodule

// File: rtl/pe_checker.sv
module pe_checker #(
  parameter int               W     = 8,
  parameter int               CNT_W = 8,
  parameter pe_pkg::pe_kind_e MODE  = pe_pkg::PE_MAC
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [W-1:0]     weight,
  input logic             step,
  input logic             bcast_bit,
  input logic             opnd_bit,
  input logic             res_bit,
  input logic [CNT_W-1:0] count
);
  import pe_pkg::*;

  localparam logic [CNT_W-1:0] TOP = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] BOT = {1'b1, {(CNT_W-1){1'b0}}};

  logic w0_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) w0_q <= 1'b0;
    else if (start) w0_q <= weight[0];
  end

  if (MODE == PE_MAC) begin : g_mac_chk
    p_start_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (res_bit == 1'b0));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !step) |=> $stable(res_bit));

    p_first_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(start) && step && !start) |=>
        (res_bit == ((w0_q & $past(bcast_bit)) ^ $past(opnd_bit))));
  end else begin : g_cnt_chk
    p_count_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !start && bcast_bit && count != TOP) |=> (count == $past(count) + 1'b1));

    p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !start && !bcast_bit && count != BOT) |=> (count == $past(count) - 1'b1));

    p_sat_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !start && bcast_bit && count == TOP) |=> (count == TOP));

    p_sat_bot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !start && !bcast_bit && count == BOT) |=> (count == BOT));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (count == '0));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !step) |=> $stable(count));
  end

endmodule

bind bsmac_pe pe_checker #(.W(W), .CNT_W(CNT_W), .MODE(MODE)) u_pe_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .weight    (weight),
  .step      (step),
  .bcast_bit (bcast_bit),
  .opnd_bit  (opnd_bit),
  .res_bit   (res_bit),
  .count     (count)
);

// File: tb/tb_bsmac_pe.sv
module tb_bsmac_pe;
  import pe_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  // multiply-accumulate instance
  logic         m_start, m_step, m_x, m_y;
  logic [W-1:0] m_w;
  logic         m_res;
  logic [7:0]   m_cnt;

  bsmac_pe #(.W(W), .CNT_W(8), .MODE(PE_MAC)) dut (
    .clk(clk), .rst_n(rst_n), .start(m_start), .weight(m_w), .step(m_step),
    .bcast_bit(m_x), .opnd_bit(m_y), .res_bit(m_res), .count(m_cnt)
  );

  // counting instance
  logic          c_start, c_step, c_up, c_opnd;
  logic [W-1:0]  c_w;
  logic          c_res;
  logic [CW-1:0] c_cnt;

  bsmac_pe #(.W(W), .CNT_W(CW), .MODE(PE_COUNT)) dut_cnt (
    .clk(clk), .rst_n(rst_n), .start(c_start), .weight(c_w), .step(c_step),
    .bcast_bit(c_up), .opnd_bit(c_opnd), .res_bit(c_res), .count(c_cnt)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int model;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint mac_expect(input longint a, input longint x, input longint y);
    return (a * x + y) & ((64'd1 << (2*W+1)) - 1);
  endfunction

  // full operation; gap>0 inserts idle cycles with toggling data between steps
  task automatic mac_run(input logic [W-1:0] a, input logic [W-1:0] x,
                         input logic [2*W-1:0] y, input int gap, input string req);
    logic [2*W:0] got;
    longint exp;
    got = '0;
    @(negedge clk);
    m_start = 1'b1; m_w = a; m_step = 1'b0;
    @(negedge clk);
    m_start = 1'b0; m_w = ~a;
    chk(m_res == 1'b0, "R5 res cleared by start", m_res, 0);
    for (int k = 0; k <= 2*W; k++) begin
      m_step = 1'b1;
      m_x = (k < W) ? x[k] : 1'b0;
      m_y = (k < 2*W) ? y[k] : 1'b0;
      @(negedge clk);
      got[k] = m_res;
      m_step = 1'b0;
      for (int g = 0; g < gap; g++) begin
        m_x = ~m_x; m_y = ~m_y;
        @(negedge clk);
        chk(m_res == got[k], "R6 res held while idle", m_res, got[k]);
      end
    end
    m_step = 1'b0;
    exp = mac_expect(a, x, y);
    chk(longint'(got) == exp, req, longint'(got), exp);
    chk(m_cnt == 8'd0, "R10 count idle in mac mode", m_cnt, 0);
  endtask

  task automatic cnt_step(input bit st, input bit sp, input bit up, input string req);
    logic [CW-1:0] e;
    c_start = st; c_step = sp; c_up = up;
    c_opnd = $urandom_range(0, 1); c_w = W'($urandom);
    @(negedge clk);
    if (st) model = 0;
    else if (sp) begin
      if (up && model < (1 << (CW-1)) - 1) model++;
      else if (!up && model > -(1 << (CW-1))) model--;
    end
    e = CW'(model);
    chk(c_cnt == e, req, c_cnt, e);
    chk(c_res == 1'b0, "R10 res idle in count mode", c_res, 0);
    c_start = 1'b0; c_step = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7731));
    rst_n = 1'b0;
    m_start = 0; m_step = 0; m_x = 0; m_y = 0; m_w = '0;
    c_start = 0; c_step = 0; c_up = 0; c_opnd = 0; c_w = '0;
    model = 0;
    repeat (3) @(negedge clk);
    chk(m_res == 1'b0, "R1 res in reset", m_res, 0);
    chk(c_cnt == '0, "R1 count in reset", c_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(m_res == 1'b0, "R1 res after reset", m_res, 0);
    chk(c_cnt == '0, "R1 count after reset", c_cnt, 0);

    // directed multiply-accumulate corners
    mac_run(8'hFF, 8'hFF, 16'hFFFF, 0, "R3 all ones with carry out");
    mac_run(8'h00, 8'hA5, 16'h1234, 0, "R4 zero weight passes addend");
    mac_run(8'h00, 8'hFF, 16'hFFFF, 0, "R4 zero weight max addend");
    mac_run(8'h9C, 8'h00, 16'h0000, 0, "R3 zero multiplier");
    mac_run(8'h81, 8'h7F, 16'h8001, 2, "R2 latency with idle gaps");

    // cut-off operation followed by a fresh one
    @(negedge clk);
    m_start = 1'b1; m_w = 8'hFF;
    @(negedge clk);
    m_start = 1'b0;
    for (int k = 0; k < 5; k++) begin
      m_step = 1'b1; m_x = 1'b1; m_y = 1'b1;
      @(negedge clk);
    end
    m_step = 1'b0;
    mac_run(8'h03, 8'h05, 16'h0001, 0, "R5 no residue after abort");

    // random multiply-accumulate
    for (int n = 0; n < 40; n++) begin
      mac_run(W'($urandom), W'($urandom), 16'($urandom), (n % 5 == 0) ? 1 : 0, "R3 random mac");
    end

    // counting mode
    cnt_step(1, 0, 0, "R9 clear");
    for (int i = 0; i < 3; i++) cnt_step(0, 1, 1, "R7 increment");
    for (int i = 0; i < 2; i++) cnt_step(0, 1, 0, "R7 decrement");
    for (int i = 0; i < 10; i++) cnt_step(0, 1, 1, "R8 saturate high");
    chk(c_cnt == 4'd7, "R8 top limit", c_cnt, 7);
    cnt_step(0, 0, 0, "R6 idle hold");
    for (int i = 0; i < 20; i++) cnt_step(0, 1, 0, "R8 saturate low");
    chk(c_cnt == 4'h8, "R8 bottom limit", c_cnt, 8);
    cnt_step(1, 1, 1, "R9 start beats step");
    for (int i = 0; i < 300; i++) begin
      cnt_step(($urandom_range(0, 39) == 0), $urandom_range(0, 3) != 0,
               $urandom_range(0, 1), "R7 random count");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule